// File: doc/BRIEF.md
# Phase-Offset PWM Bank

This block drives a set of independent pulse-width-modulated lines from one counting clock. Each channel is described by three cycle counts: the length of its period, how long its line stays high, and how far the rising edge is delayed from the start of the period. The waveform values come in on input buses that are always present. The block samples them only when the `load` strobe is high. Between loads the buses can change freely without any effect on the lines.

A load can take effect at once, or it can be held until every running channel finishes its period together. The `force_align` input chooses between these. An immediate load restarts the counters of all channels from zero, so all channels stay in phase with each other. A held load is kept in a pending copy. It is applied on the first cycle in which every enabled channel sits on the last count of its period. A later load replaces that pending copy. A channel with a zero period is disabled. The polarity is always active-high.

Top module: `pwm_bank`

## Requirements
- R1: While `rst` is high, and on the cycle after it, every line of `pwm_out` is low. After reset, every channel is disabled until the first load takes effect.
- R2: A change on `period_in`, `duty_in` or `offset_in` without a `load` pulse has no effect on `pwm_out`.
- R3: A `load` with `force_align` high replaces the active values of all channels at that clock edge and restarts every counter at 0. The line level for count k shows on `pwm_out` one cycle after the counter holds k.
- R4: An enabled channel counts 0 to period-1 and wraps. Its line is high while the count is at least the offset and less than offset plus duty.
- R5: A `load` with `force_align` low stores the inputs as pending. The pending values become active, with all counters restarting at 0, on the first later edge at which every enabled channel's counter is at period-1. A bank with no enabled channel meets this condition at once.
- R6: A second load before a pending load is applied replaces the pending values. A forced load clears any pending load.
- R7: A channel whose active period is 0 holds its line low.
- R8: A duty larger than the period keeps the line high from the offset to the end of each period.
- R9: An offset greater than or equal to the period keeps the line low.
- R10: A duty of 0 keeps the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high core reset |
| load | input | 1 | Strobe that samples the waveform input buses |
| force_align | input | 1 | 1: load applies at once; 0: load waits for a common period end |
| period_in | input | NUM_CH*CNT_W | Period per channel, channel c in bits [c*CNT_W +: CNT_W] |
| duty_in | input | NUM_CH*CNT_W | High time per channel, same packing |
| offset_in | input | NUM_CH*CNT_W | Rising-edge delay per channel, same packing |
| pwm_out | output | NUM_CH | Registered PWM lines, bit c for channel c |

## Verification
A fixed pattern with one ordinary channel, one disabled channel, one with duty beyond its period and one with offset at its period is checked cycle by cycle against hard-coded waveforms. This pattern separates the windowing, clipping and disabling rules. Input changes with no load, held loads on channels with periods of 4 and 3 (common end only every 12 cycles), and a double held load show whether updates are held, when they land, and which values win. Random rounds of periods, duties and offsets, mixed with forced, held and absent loads, are compared on every cycle against a behavioural model in the bench.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // What the load controller asks every channel to do at the next edge.
  typedef enum logic [1:0] {
    ACT_RUN    = 2'd0,  // keep counting
    ACT_STORE  = 2'd1,  // capture inputs into the pending copy
    ACT_FORCE  = 2'd2,  // inputs become active now, counters restart
    ACT_COMMIT = 2'd3   // pending copy becomes active, counters restart
  } chan_act_e;

endpackage

// File: rtl/pwm_load_ctrl.sv
module pwm_load_ctrl
  import pwm_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      force_align,
  input  logic      all_last,
  output chan_act_e action,
  output logic      pending
);

  logic pend_q;

  always_comb begin
    if (load && force_align)      action = ACT_FORCE;
    else if (load)                action = ACT_STORE;
    else if (pend_q && all_last)  action = ACT_COMMIT;
    else                          action = ACT_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      unique case (action)
        ACT_STORE:            pend_q <= 1'b1;
        ACT_FORCE, ACT_COMMIT: pend_q <= 1'b0;
        default:              pend_q <= pend_q;
      endcase
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  chan_act_e        action,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] off_in,
  output logic             line,
  output logic             at_last,
  output logic [CNT_W-1:0] act_per,
  output logic [CNT_W-1:0] act_off,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pnd_per, pnd_duty, pnd_off;
  logic [CNT_W-1:0] a_per, a_duty, a_off;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             en, level, line_q;

  assign en      = (a_per != '0);
  assign at_last = !en || (cnt_q == a_per - ONE);
  assign cnt_next = at_last ? '0 : cnt_q + ONE;
  // cnt_q < a_per, so a duty beyond the period clips at the wrap
  assign level   = en && (cnt_q >= a_off) && ((cnt_q - a_off) < a_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      pnd_per  <= '0;
      pnd_duty <= '0;
      pnd_off  <= '0;
      a_per    <= '0;
      a_duty   <= '0;
      a_off    <= '0;
      cnt_q    <= '0;
      line_q   <= 1'b0;
    end else begin
      line_q <= level;
      unique case (action)
        ACT_FORCE: begin
          a_per  <= per_in;
          a_duty <= duty_in;
          a_off  <= off_in;
          cnt_q  <= '0;
        end
        ACT_COMMIT: begin
          a_per  <= pnd_per;
          a_duty <= pnd_duty;
          a_off  <= pnd_off;
          cnt_q  <= '0;
        end
        ACT_STORE: begin
          pnd_per  <= per_in;
          pnd_duty <= duty_in;
          pnd_off  <= off_in;
          cnt_q    <= cnt_next;
        end
        default: cnt_q <= cnt_next;
      endcase
    end
  end

  assign line    = line_q;
  assign act_per = a_per;
  assign act_off = a_off;
  assign count   = cnt_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    force_align,
  input  logic [NUM_CH*CNT_W-1:0] period_in,
  input  logic [NUM_CH*CNT_W-1:0] duty_in,
  input  logic [NUM_CH*CNT_W-1:0] offset_in,
  output logic [NUM_CH-1:0]       pwm_out
);

  localparam int BUS_W = NUM_CH * CNT_W;

  chan_act_e         action;
  logic              pending_q;
  logic [NUM_CH-1:0] last_v;
  logic              all_last;
  logic [BUS_W-1:0]  act_per_flat, act_off_flat, cnt_flat;

  assign all_last = &last_v;

  pwm_load_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .force_align (force_align),
    .all_last    (all_last),
    .action      (action),
    .pending     (pending_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .action  (action),
      .per_in  (period_in[c*CNT_W +: CNT_W]),
      .duty_in (duty_in[c*CNT_W +: CNT_W]),
      .off_in  (offset_in[c*CNT_W +: CNT_W]),
      .line    (pwm_out[c]),
      .at_last (last_v[c]),
      .act_per (act_per_flat[c*CNT_W +: CNT_W]),
      .act_off (act_off_flat[c*CNT_W +: CNT_W]),
      .count   (cnt_flat[c*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    load,
  input logic                    force_align,
  input logic [NUM_CH-1:0]       pwm_out,
  input logic [NUM_CH*CNT_W-1:0] act_per,
  input logic [NUM_CH*CNT_W-1:0] act_off,
  input logic [NUM_CH*CNT_W-1:0] cnt,
  input logic                    pending
);

  // R1: outputs low on the cycle after reset is sampled
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (pwm_out == '0));

  // R2: with no load and nothing pending the active periods hold
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && !pending) |=> $stable(act_per));

  // R5: a held load raises the pending flag
  assert_pend_set_R5: assert property (@(posedge clk) disable iff (rst)
    (load && !force_align) |=> pending);

  // R6: a forced load clears the pending flag
  assert_force_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (load && force_align) |=> !pending);

  // R3: a forced load restarts every counter
  assert_force_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (load && force_align) |=> (cnt == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4: counter stays inside the period
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
      (act_per[c*CNT_W +: CNT_W] != '0) |->
        (cnt[c*CNT_W +: CNT_W] < act_per[c*CNT_W +: CNT_W]));

    // R7: zero period gives a low line
    assert_zero_period_R7: assert property (@(posedge clk) disable iff (rst)
      (act_per[c*CNT_W +: CNT_W] == '0) |=> !pwm_out[c]);

    // R9: offset at or past the period gives a low line
    assert_offset_low_R9: assert property (@(posedge clk) disable iff (rst)
      (act_off[c*CNT_W +: CNT_W] >= act_per[c*CNT_W +: CNT_W]) |=> !pwm_out[c]);
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load        (load),
  .force_align (force_align),
  .pwm_out     (pwm_out),
  .act_per     (act_per_flat),
  .act_off     (act_off_flat),
  .cnt         (cnt_flat),
  .pending     (pending_q)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

  localparam int NCH = 4;
  localparam int W   = 32;
  localparam int WATCH_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic force_align = 1'b0;
  logic [NCH*W-1:0] period_in, duty_in, offset_in;
  logic [NCH-1:0] pwm_out;

  logic [W-1:0] s_per [NCH];
  logic [W-1:0] s_dut [NCH];
  logic [W-1:0] s_off [NCH];

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      period_in[c*W +: W] = s_per[c];
      duty_in[c*W +: W]   = s_dut[c];
      offset_in[c*W +: W] = s_off[c];
    end
  end

  pwm_bank #(.NUM_CH(NCH), .CNT_W(W)) i_pwm_bank (
    .clk(clk), .rst(rst), .load(load), .force_align(force_align),
    .period_in(period_in), .duty_in(duty_in), .offset_in(offset_in),
    .pwm_out(pwm_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Behavioural reference built from the requirements
  logic [W-1:0] m_per [NCH], m_dut [NCH], m_off [NCH], m_cnt [NCH];
  logic [W-1:0] p_per [NCH], p_dut [NCH], p_off [NCH];
  logic [NCH-1:0] m_out;
  bit m_pend, m_valid;

  function automatic bit want_high(input logic [W-1:0] per, dut, off, cnt);
    if (per == 0) return 0;
    if (off >= per) return 0;
    return (cnt >= off) && (cnt < off + dut || dut > per);
  endfunction

  always @(posedge clk) begin
    bit every_last;
    m_valid = 1;
    if (rst) begin
      m_out = '0; m_pend = 0;
      for (int c = 0; c < NCH; c++) begin
        m_per[c] = 0; m_dut[c] = 0; m_off[c] = 0; m_cnt[c] = 0;
        p_per[c] = 0; p_dut[c] = 0; p_off[c] = 0;
      end
    end else begin
      every_last = 1;
      for (int c = 0; c < NCH; c++) begin
        m_out[c] = want_high(m_per[c], m_dut[c], m_off[c], m_cnt[c]);
        if (m_per[c] != 0 && m_cnt[c] != m_per[c] - 1) every_last = 0;
      end
      if (load && force_align) begin
        m_pend = 0;
        for (int c = 0; c < NCH; c++) begin
          m_per[c] = s_per[c]; m_dut[c] = s_dut[c]; m_off[c] = s_off[c]; m_cnt[c] = 0;
        end
      end else if (!load && m_pend && every_last) begin
        m_pend = 0;
        for (int c = 0; c < NCH; c++) begin
          m_per[c] = p_per[c]; m_dut[c] = p_dut[c]; m_off[c] = p_off[c]; m_cnt[c] = 0;
        end
      end else begin
        if (load) begin
          m_pend = 1;
          for (int c = 0; c < NCH; c++) begin
            p_per[c] = s_per[c]; p_dut[c] = s_dut[c]; p_off[c] = s_off[c];
          end
        end
        for (int c = 0; c < NCH; c++)
          m_cnt[c] = (m_per[c] == 0 || m_cnt[c] == m_per[c] - 1) ? 0 : m_cnt[c] + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done)
      chk(pwm_out === m_out, cur_req, 32'(pwm_out), 32'(m_out));
  end

  task automatic set_ch(input int c, input int per, input int dut, input int off);
    s_per[c] = per; s_dut[c] = dut; s_off[c] = off;
  endtask

  task automatic pulse_load(input bit frc);
    @(negedge clk);
    load = 1'b1; force_align = frc;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(WATCH_CYCLES * 20);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm_out == '0, "R1 in reset", 32'(pwm_out), 0);
    rst = 1'b0;
    set_ch(0, 5, 2, 0);
    repeat (6) begin
      @(negedge clk);
      chk(pwm_out == '0, "R1 disabled after reset", 32'(pwm_out), 0);
    end

    // Directed: windowing, disable, duty clip, offset at period
    cur_req = "R3 R4 R7 R8 R9";
    set_ch(0, 4, 2, 1);
    set_ch(1, 0, 3, 0);
    set_ch(2, 3, 9, 1);
    set_ch(3, 3, 2, 3);
    @(negedge clk);
    load = 1'b1; force_align = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    for (int k = 0; k < 12; k++) begin
      logic [3:0] exp;
      @(posedge clk);
      @(negedge clk);
      exp = '0;
      exp[0] = (k % 4 == 1) || (k % 4 == 2);
      exp[2] = (k % 3 != 0);
      chk(pwm_out[0] == exp[0], "R4 window ch0", 32'(pwm_out[0]), 32'(exp[0]));
      chk(pwm_out[1] == 1'b0, "R7 zero period", 32'(pwm_out[1]), 0);
      chk(pwm_out[2] == exp[2], "R8 duty clip", 32'(pwm_out[2]), 32'(exp[2]));
      chk(pwm_out[3] == 1'b0, "R9 offset at period", 32'(pwm_out[3]), 0);
    end

    // Inputs change without load
    cur_req = "R2";
    set_ch(0, 7, 7, 0); set_ch(1, 2, 1, 0); set_ch(3, 5, 5, 0);
    repeat (20) @(negedge clk);

    // Held load waits for common end of periods 4 and 3
    cur_req = "R5";
    set_ch(0, 6, 3, 2); set_ch(1, 5, 2, 1); set_ch(2, 3, 1, 0); set_ch(3, 4, 0, 0);
    pulse_load(1'b0);
    repeat (30) @(negedge clk);

    // Second held load replaces the first; a forced one clears pending
    cur_req = "R6";
    set_ch(0, 8, 4, 0);
    pulse_load(1'b0);
    set_ch(0, 9, 1, 3); set_ch(1, 2, 1, 1);
    pulse_load(1'b0);
    repeat (40) @(negedge clk);
    set_ch(0, 5, 3, 1);
    pulse_load(1'b0);
    set_ch(0, 7, 2, 2);
    pulse_load(1'b1);
    repeat (30) @(negedge clk);

    // Zero duty everywhere
    cur_req = "R10";
    for (int c = 0; c < NCH; c++) set_ch(c, 3 + c, 0, 0);
    pulse_load(1'b1);
    repeat (15) begin
      @(negedge clk);
      chk(pwm_out == '0, "R10 zero duty", 32'(pwm_out), 0);
    end

    // Random rounds
    for (int it = 0; it < 400; it++) begin
      int kind;
      for (int c = 0; c < NCH; c++)
        set_ch(c, $urandom_range(0, 10), $urandom_range(0, 12), $urandom_range(0, 11));
      kind = $urandom_range(0, 2);
      if (kind == 0) begin
        cur_req = "R2";
        repeat ($urandom_range(1, 20)) @(negedge clk);
      end else begin
        cur_req = (kind == 1) ? "R3" : "R5";
        pulse_load(kind == 1);
        repeat ($urandom_range(1, 40)) @(negedge clk);
      end
    end

    finish_run();
  end

endmodule